// File: doc/BRIEF.md
# Duty-Cycle Converter Digital Back-End

This block is the digital half of a pulse-width-modulated analog-to-digital converter. A comparator result arrives as a one-bit input. The block registers it on every rising clock edge. The registered bit drives the external reference switch and also gates clock pulses into a result counter. A free-running window counter divides time into windows of `WINDOW` clocks. At the end of each window, the gated count is the input-to-reference ratio scaled by `WINDOW`. That count is then converted to four BCD digits.

A finished conversion moves into the output latches only when a start request is pending. A host raises `start` and waits for `cc_o` to rise. It then reads the digits one at a time by putting a digit number on `addr`. The digit number can be frozen with `dle`. Holding `start` high gives a fresh result after every window.

The converter state machine has three states:
- `CV_IDLE` waits for the end of a window. On that pulse it takes the count and the polarity and goes to `CV_SHIFT`.
- `CV_SHIFT` runs one shift-and-adjust step per clock, for as many clocks as the count has bits. After the last step it goes to `CV_DONE`.
- `CV_DONE` lasts one cycle, offers the result to the output stage, and returns to `CV_IDLE`.

Top module: `dcadc_backend`

## Requirements
- R1: `sw_o` equals `cmp_in` delayed by exactly one rising clock edge.
- R2: The window counter and the result counter start at reset and run continuously. Each window lasts `WINDOW` clocks. A window's result is the number of its clocks in which `sw_o` was high, from 0 to `WINDOW`.
- R3: Results are presented as BCD on `digit_o`, each digit in the range 0 to 9. Address 0 selects the units digit, 1 the tens, 2 the hundreds and 3 the thousands (most significant) digit. The most significant digit never exceeds `WINDOW`/1000.
- R4: A result equal to `WINDOW` is overrange. All four digits then read 0xE and `ovf_o` is 1. Any smaller result gives `ovf_o` = 0.
- R5: `sign_o` is 0 when `neg_in` was high at the end of the converted window, and 1 otherwise.
- R6: While `dle` is 0, `addr` selects the digit directly. While `dle` is 1, the selection is frozen at the `addr` value seen at the last rising edge with `dle` low.
- R7: A `start` seen at a rising edge drives `cc_o` low from that edge. `cc_o` then stays low until the next transfer.
- R8: A start request stays pending until a conversion completes. That completion loads the output latches and drives `cc_o` high. With no request, finished conversions change neither the latches nor `cc_o`.
- R9: A `start` in the cycle a conversion completes is served by that completion. With `start` held high, `cc_o` is high for exactly one cycle per window and the result is refreshed every window.
- R10: After reset, `cc_o` = 0, every digit reads 0, `sign_o` = 1, `ovf_o` = 0 and `sw_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_in | input | 1 | Comparator result from the analog loop |
| neg_in | input | 1 | Front end reports an inverted (negative) input |
| start | input | 1 | Start request, pulse or level |
| dle | input | 1 | Digit address hold enable |
| addr | input | 2 | Digit number, 0 = units .. 3 = thousands |
| sw_o | output | 1 | Registered duty bit to the reference switch |
| digit_o | output | 4 | Selected BCD digit |
| sign_o | output | 1 | Polarity, low for negative |
| ovf_o | output | 1 | Overrange flag |
| cc_o | output | 1 | Conversion complete |

## Verification
A start request and the transfer of a finished conversion can land on the same clock edge. The bench provokes this collision on every window by holding `start` high through several windows. It then counts the cycles in which `cc_o` is high over exactly two windows and expects two. It also expects the latched value to follow the newest input pattern. If a colliding request were dropped, or kept pending without being served, that count and the refresh would differ.

// File: rtl/dcadc_pkg.sv
package dcadc_pkg;

    typedef enum logic [1:0] {
        CV_IDLE  = 2'd0,
        CV_SHIFT = 2'd1,
        CV_DONE  = 2'd2
    } cv_state_e;

    function automatic logic [3:0] add3_if_big(input logic [3:0] nib);
        return (nib >= 4'd5) ? nib + 4'd3 : nib;
    endfunction

endpackage

// File: rtl/dc_window.sv
module dc_window #(
    parameter int N  = 2000,
    parameter int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmp_in,
    output logic          duty_o,
    output logic          win_end_o,
    output logic [CW-1:0] snap_o
);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] win_cnt;
    logic [CW-1:0] acc;
    logic [CW-1:0] duty_ext;

    assign duty_ext  = {{(CW-1){1'b0}}, duty_o};
    assign win_end_o = (win_cnt == LAST);
    assign snap_o    = acc + duty_ext;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_o  <= 1'b0;
            win_cnt <= '0;
            acc     <= '0;
        end else begin
            duty_o <= cmp_in;
            if (win_end_o) begin
                win_cnt <= '0;
                acc     <= '0;
            end else begin
                win_cnt <= win_cnt + 1'b1;
                acc     <= acc + duty_ext;
            end
        end
    end

    // R2: gated pulses can never outnumber clocks elapsed in the window
    assert_acc_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc <= win_cnt);

    // R1: switch bit follows the comparator by one edge
    assert_duty_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && $past(rst_n) |-> duty_o == $past(cmp_in));
endmodule

// File: rtl/dc_bcd.sv
module dc_bcd
    import dcadc_pkg::*;
#(
    parameter int N      = 2000,
    parameter int CW     = $clog2(N + 1),
    parameter int DIGITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [CW-1:0]       bin_i,
    input  logic                neg_i,
    output logic                ready_o,
    output logic [4*DIGITS-1:0] bcd_o,
    output logic                neg_o,
    output logic                ovr_o
);
    localparam int            BW      = 4 * DIGITS;
    localparam int            KW      = $clog2(CW + 1);
    localparam logic [KW-1:0] KLAST   = KW'(CW - 1);
    localparam logic [CW-1:0] FULL    = CW'(N);
    localparam logic [3:0]    MAX_MSD = 4'(N / 1000);

    cv_state_e     state, nxt;
    logic [CW-1:0] shreg;
    logic [KW-1:0] step;
    logic [BW-1:0] adj;

    genvar g;
    generate
        for (g = 0; g < DIGITS; g++) begin : g_adj
            assign adj[g*4 +: 4] = add3_if_big(bcd_o[g*4 +: 4]);
        end
    endgenerate

    always_comb begin
        nxt = state;
        unique case (state)
            CV_IDLE:  if (load_i) nxt = CV_SHIFT;
            CV_SHIFT: if (step == KLAST) nxt = CV_DONE;
            CV_DONE:  nxt = CV_IDLE;
            default:  nxt = CV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CV_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            step  <= '0;
            bcd_o <= '0;
            neg_o <= 1'b0;
            ovr_o <= 1'b0;
        end else begin
            unique case (state)
                CV_IDLE: if (load_i) begin
                    shreg <= bin_i;
                    step  <= '0;
                    bcd_o <= '0;
                    neg_o <= neg_i;
                    ovr_o <= (bin_i >= FULL);
                end
                CV_SHIFT: begin
                    bcd_o <= {adj[BW-2:0], shreg[CW-1]};
                    shreg <= shreg << 1;
                    step  <= step + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign ready_o = (state == CV_DONE);

    // R3: every finished digit is decimal and the top digit is bounded
    assert_digit_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (bcd_o[BW-1 -: 4] <= MAX_MSD) && (bcd_o[11:8] <= 4'd9)
                    && (bcd_o[7:4] <= 4'd9) && (bcd_o[3:0] <= 4'd9));

    // R2: a new window never arrives while a conversion is in flight
    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state != CV_IDLE |-> !load_i);
endmodule

// File: rtl/dc_port.sv
module dc_port #(
    parameter int DIGITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                ready_i,
    input  logic [4*DIGITS-1:0] bcd_i,
    input  logic                neg_i,
    input  logic                ovr_i,
    input  logic                dle_i,
    input  logic [1:0]          addr_i,
    output logic [3:0]          digit_o,
    output logic                sign_o,
    output logic                ovf_o,
    output logic                cc_o
);
    localparam int BW = 4 * DIGITS;

    logic          pending;
    logic          xfer;
    logic [BW-1:0] lat;
    logic [1:0]    addr_hold;
    logic [1:0]    sel;

    assign xfer    = ready_i && (pending || start_i);
    assign sel     = dle_i ? addr_hold : addr_i;
    assign digit_o = lat[{sel, 2'b00} +: 4];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending   <= 1'b0;
            cc_o      <= 1'b0;
            lat       <= '0;
            sign_o    <= 1'b1;
            ovf_o     <= 1'b0;
            addr_hold <= '0;
        end else begin
            if (!dle_i) addr_hold <= addr_i;
            if (xfer) begin
                pending <= 1'b0;
                cc_o    <= 1'b1;
                lat     <= ovr_i ? {DIGITS{4'hE}} : bcd_i;
                sign_o  <= ~neg_i;
                ovf_o   <= ovr_i;
            end else if (start_i) begin
                pending <= 1'b1;
                cc_o    <= 1'b0;
            end
        end
    end

    assert_cc_falls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !ready_i |=> !cc_o);

    assert_xfer_sets_cc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready_i && (pending || start_i) |=> cc_o);

    assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_i && (pending || start_i)) |=> $stable(lat) && $stable(ovf_o) && $stable(sign_o));

    assert_overrange_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> lat == {DIGITS{4'hE}});

    assert_addr_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dle_i && $past(dle_i) |-> sel == $past(sel));
endmodule

// File: rtl/dcadc_backend.sv
module dcadc_backend #(
    parameter int WINDOW = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmp_in,
    input  logic       neg_in,
    input  logic       start,
    input  logic       dle,
    input  logic [1:0] addr,
    output logic       sw_o,
    output logic [3:0] digit_o,
    output logic       sign_o,
    output logic       ovf_o,
    output logic       cc_o
);
    localparam int CW     = $clog2(WINDOW + 1);
    localparam int DIGITS = 4;

    logic                win_end;
    logic [CW-1:0]       snap;
    logic                ready;
    logic [4*DIGITS-1:0] bcd;
    logic                neg_c;
    logic                ovr_c;

    dc_window #(.N(WINDOW), .CW(CW)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_in   (cmp_in),
        .duty_o   (sw_o),
        .win_end_o(win_end),
        .snap_o   (snap)
    );

    dc_bcd #(.N(WINDOW), .CW(CW), .DIGITS(DIGITS)) u_bcd (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (win_end),
        .bin_i  (snap),
        .neg_i  (neg_in),
        .ready_o(ready),
        .bcd_o  (bcd),
        .neg_o  (neg_c),
        .ovr_o  (ovr_c)
    );

    dc_port #(.DIGITS(DIGITS)) u_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start),
        .ready_i(ready),
        .bcd_i  (bcd),
        .neg_i  (neg_c),
        .ovr_i  (ovr_c),
        .dle_i  (dle),
        .addr_i (addr),
        .digit_o(digit_o),
        .sign_o (sign_o),
        .ovf_o  (ovf_o),
        .cc_o   (cc_o)
    );
endmodule

// File: tb/dcadc_backend_tb.sv
module dcadc_backend_tb;
    localparam int N = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_in = 1'b0;
    logic neg_in = 1'b0;
    logic start = 1'b0;
    logic dle = 1'b0;
    logic [1:0] addr = 2'd0;
    logic sw_o, sign_o, ovf_o, cc_o;
    logic [3:0] digit_o;

    int checks = 0;
    int fails = 0;
    int pat_p = 1;
    int pat_h = 0;
    int phase = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dcadc_backend #(.WINDOW(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .neg_in(neg_in),
        .start(start), .dle(dle), .addr(addr), .sw_o(sw_o),
        .digit_o(digit_o), .sign_o(sign_o), .ovf_o(ovf_o), .cc_o(cc_o)
    );

    always @(negedge clk) begin
        phase  = phase + 1;
        cmp_in = ((phase % pat_p) < pat_h);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_pattern(input int p, input int h, input bit neg);
        @(posedge clk);
        #1;
        pat_p  = p;
        pat_h  = h;
        neg_in = neg;
    endtask

    task automatic read_digit(input int a, output int d);
        @(negedge clk);
        dle  = 1'b0;
        addr = 2'(a);
        #1;
        d = int'(digit_o);
    endtask

    task automatic wait_cc(input string req);
        int n = 0;
        while (cc_o !== 1'b1 && n < 3 * N) begin
            @(negedge clk);
            #1;
            n++;
        end
        check(cc_o === 1'b1, req, int'(cc_o), 1);
    endtask

    task automatic expect_result(input int cnt, input bit neg, input string req);
        int d;
        int e;
        check(ovf_o == (cnt >= N), "R4", int'(ovf_o), int'(cnt >= N));
        check(sign_o == !neg, "R5", int'(sign_o), int'(!neg));
        for (int a = 0; a < 4; a++) begin
            read_digit(a, d);
            e = (cnt >= N) ? 14 : (cnt / (10 ** a)) % 10;
            check(d == e, req, d, e);
        end
    endtask

    // R7, R8, R3: one requested conversion of a settled pattern
    task automatic convert(input int p, input int h, input bit neg, input int cnt, input string req);
        set_pattern(p, h, neg);
        wait_cycles(2 * N + 20);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        check(cc_o == 1'b0, "R7", int'(cc_o), 0);
        wait_cc("R8");
        expect_result(cnt, neg, req);
    endtask

    task automatic test_reset();
        int d;
        check(cc_o == 1'b0, "R10", int'(cc_o), 0);
        check(sign_o == 1'b1, "R10", int'(sign_o), 1);
        check(ovf_o == 1'b0, "R10", int'(ovf_o), 0);
        check(sw_o == 1'b0, "R10", int'(sw_o), 0);
        for (int a = 0; a < 4; a++) begin
            read_digit(a, d);
            check(d == 0, "R10", d, 0);
        end
    endtask

    task automatic test_switch_delay();
        set_pattern(1, 1, 1'b0);
        @(negedge clk);
        #1;
        check(sw_o == 1'b0, "R1", int'(sw_o), 0);
        @(negedge clk);
        #1;
        check(sw_o == 1'b1, "R1", int'(sw_o), 1);
        set_pattern(1, 0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        #1;
        check(sw_o == 1'b0, "R1", int'(sw_o), 0);
    endtask

    // R6: frozen digit selection; the result currently latched is 0625
    task automatic test_addr_hold();
        @(negedge clk);
        dle  = 1'b0;
        addr = 2'd2;
        @(negedge clk);
        dle  = 1'b1;
        addr = 2'd0;
        #1;
        check(digit_o == 4'd6, "R6", int'(digit_o), 6);
        @(negedge clk);
        addr = 2'd1;
        #1;
        check(digit_o == 4'd6, "R6", int'(digit_o), 6);
        @(negedge clk);
        dle = 1'b0;
        #1;
        check(digit_o == 4'd2, "R6", int'(digit_o), 2);
    endtask

    // R8: without a request, new windows leave the outputs alone
    task automatic test_no_request();
        set_pattern(4, 1, 1'b0);
        wait_cycles(3 * N);
        check(cc_o == 1'b1, "R8", int'(cc_o), 1);
        expect_result(625, 1'b1, "R8");
    endtask

    // R9: request held across transfers
    task automatic test_continuous();
        int highs = 0;
        set_pattern(8, 3, 1'b0);
        @(negedge clk);
        start = 1'b1;
        wait_cycles(2 * N + 20);
        for (int i = 0; i < 2 * N; i++) begin
            @(negedge clk);
            #1;
            if (cc_o) highs++;
        end
        check(highs == 2, "R9", highs, 2);
        @(negedge clk);
        start = 1'b0;
        wait_cc("R9");
        expect_result(750, 1'b0, "R9");
    endtask

    initial begin
        wait_cycles(4);
        #1;
        test_reset();
        @(negedge clk);
        rst_n = 1'b1;
        test_switch_delay();
        convert(1, 0, 1'b0, 0, "R2");
        convert(8, 3, 1'b0, 750, "R2");
        convert(N, N - 1, 1'b0, N - 1, "R3");
        convert(1, 1, 1'b0, N, "R4");
        convert(16, 5, 1'b1, 625, "R5");
        test_addr_hold();
        test_no_request();
        test_continuous();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        wait_cycles(190000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule